// File: doc/BRIEF.md
# Multiplexed DRAM Burst Controller

This block converts a simple word-request handshake into the pin sequence an asynchronous DRAM with a shared row/column address bus expects. When a request is accepted, the block splits the word address into a row field and a column field. It puts the row on the address bus and latches it with a falling row strobe. It then puts the column on the bus and latches it with a falling column strobe. A burst always covers four words at consecutive columns of one row.

A two-bit timing selector, sampled when the request is accepted, picks one of three burst patterns:

- **Conventional:** every word repeats the whole row-and-column sequence, costing 5-5-5-5 clocks.
- **Page:** the row strobe stays low after the first word. Each later word costs three clocks: new column with the column strobe high, column strobe low, then capture while it is still low. This gives 5-3-3-3.
- **Extended output:** the block relies on the memory holding its output after the column strobe rises. It captures each word in the cycle where it presents the next column, giving 5-2-2-2.

For writes, the block holds the write-enable pin low and drives each word onto the data lines ahead of its column strobe. For reads, it returns each word with a one-cycle valid pulse. An external refresh arbiter holds off new bursts through a grant input.

Top module: `dram_burst_ctrl`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n and dram_we_n are 1, dram_dq_oe is 0, and ack and rd_valid are 0.
- R2: The row is req_addr[7:0] and the column is req_addr[13:8]. The row is on dram_addr when dram_ras_n falls. The column is on dram_addr when dram_cas_n falls, which happens only while dram_ras_n has been low for at least one cycle. dram_addr does not change while dram_cas_n is low.
- R3: Every burst has exactly four column-strobe falls, at columns c, c+1, c+2, c+3 modulo 64, within the accepted row. A burst starting at column 62 uses columns 62, 63, 0, 1 of the same row and leaves other rows unchanged.
- R4: With req_mode=0 (conventional), dram_ras_n falls once per word (four times), and rd_valid is high in the cycles 5, 10, 15 and 20 after the ack cycle.
- R5: With req_mode=1 (page), dram_ras_n falls once per burst, and rd_valid is high in cycles 5, 8, 11 and 14 after the ack cycle. Every word is captured while dram_cas_n is still low.
- R6: With req_mode=2 or 3 (extended output), dram_ras_n falls once per burst, and rd_valid is high in cycles 5, 7, 9 and 11 after the ack cycle. Later words are captured while dram_cas_n is high.
- R7: With req_we=1, dram_we_n is 0 and dram_dq_oe is 1 at every column-strobe fall. At the fall for word k, dram_dq_out already holds req_wdata[16k+15:16k]. rd_valid stays 0 for the whole write burst.
- R8: While refresh_grant is 1, no request is acknowledged and dram_ras_n stays 1. A request still pending when the grant drops is acknowledged in the next cycle.
- R9: ack is a one-cycle pulse, seen one cycle after a request is accepted while the block is idle. dram_ras_n is 1 in the ack cycle, so the row strobe is high between bursts. One request yields exactly one ack.
- R10: req_mode is sampled at acceptance. Changing it during a burst does not alter that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Burst request, held until ack |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| req_mode | input | 2 | Timing: 0 conventional, 1 page, 2/3 extended output |
| req_addr | input | ROW_W+COL_W | Start word address: row in low bits, column above |
| req_wdata | input | BURST*DATA_W | Write words, word 0 in the low bits |
| refresh_grant | input | 1 | Refresh owns the memory; blocks new bursts |
| ack | output | 1 | Request accepted (one-cycle pulse) |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | rd_data holds a new word |
| dram_addr | output | ADDR_BUS_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Read data from memory |

## Verification
The bench builds the block with its defaults: 8 row bits, 6 column bits, 16-bit words and four-word bursts. Because the column field is only six bits wide, a burst starting at column 62 reaches the in-row wrap directly. A bench memory model delivers read data one clock after the column strobe falls. In conventional and page timing the model spoils that data once the strobe rises; in extended-output timing it holds it. A capture placed in the wrong cycle for the selected pattern therefore shows up as wrong data, as does a wrong valid-cycle offset.

// File: rtl/dram_burst_pkg.sv
package dram_burst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_CAP,
    ST_PG_COL,
    ST_PG_CAS,
    ST_EX_COL,
    ST_EX_CAS
  } seq_state_t;

  typedef enum logic [1:0] {
    TIM_CONV,
    TIM_PAGE,
    TIM_EXT
  } timing_t;

  function automatic timing_t decode_timing(input logic [1:0] sel);
    case (sel)
      2'd0:    decode_timing = TIM_CONV;
      2'd1:    decode_timing = TIM_PAGE;
      default: decode_timing = TIM_EXT;
    endcase
  endfunction

endpackage

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dram_burst_pkg::*;
#(
  parameter int BURST = 4,
  parameter int IDX_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  input  logic [1:0]       req_mode,
  input  logic             refresh_grant,
  output logic             accept,
  output logic             load_row,
  output logic             load_col,
  output logic [IDX_W-1:0] col_idx,
  output logic             cap_rd,
  output logic             ack,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             dq_oe
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BURST - 1);

  seq_state_t       state, nxt;
  timing_t          tim_q;
  logic             we_q, we_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             last_q, last_nx;

  always_comb begin
    nxt      = state;
    idx_nx   = idx_q;
    last_nx  = last_q;
    accept   = 1'b0;
    load_row = 1'b0;
    load_col = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req && !refresh_grant) begin
          accept   = 1'b1;
          load_row = 1'b1;
          nxt      = ST_ROW;
          idx_nx   = '0;
          last_nx  = 1'b0;
        end
      end
      ST_ROW: nxt = ST_RAS;
      ST_RAS: begin
        nxt      = ST_COL;
        load_col = 1'b1;
      end
      ST_COL: nxt = ST_CAS;
      ST_CAS, ST_EX_CAS: begin
        if (tim_q == TIM_EXT) begin
          nxt = ST_EX_COL;
          if (idx_q == LAST) begin
            last_nx = 1'b1;
          end else begin
            idx_nx   = idx_q + 1'b1;
            load_col = 1'b1;
          end
        end else begin
          nxt = ST_CAP;
        end
      end
      ST_CAP: begin
        if (idx_q == LAST) begin
          nxt = ST_IDLE;
        end else begin
          idx_nx = idx_q + 1'b1;
          if (tim_q == TIM_CONV) begin
            nxt      = ST_ROW;
            load_row = 1'b1;
          end else begin
            nxt      = ST_PG_COL;
            load_col = 1'b1;
          end
        end
      end
      ST_PG_COL: nxt = ST_PG_CAS;
      ST_PG_CAS: nxt = ST_CAP;
      ST_EX_COL: nxt = last_q ? ST_IDLE : ST_EX_CAS;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign col_idx = idx_nx;
  assign we_nx   = accept ? req_we : we_q;
  assign cap_rd  = !we_q && ((state == ST_CAP) || (state == ST_EX_COL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tim_q  <= TIM_CONV;
      we_q   <= 1'b0;
      idx_q  <= '0;
      last_q <= 1'b0;
      ack    <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      dq_oe  <= 1'b0;
    end else begin
      state  <= nxt;
      idx_q  <= idx_nx;
      last_q <= last_nx;
      if (accept) begin
        tim_q <= decode_timing(req_mode);
        we_q  <= req_we;
      end
      ack   <= accept;
      ras_n <= !(nxt inside {ST_RAS, ST_COL, ST_CAS, ST_CAP, ST_PG_COL,
                             ST_PG_CAS, ST_EX_COL, ST_EX_CAS});
      cas_n <= !(nxt inside {ST_CAS, ST_CAP, ST_PG_CAS, ST_EX_CAS});
      we_n  <= !((nxt != ST_IDLE) && we_nx);
      dq_oe <= (nxt != ST_IDLE) && we_nx;
    end
  end

  // R2: column strobe falls only after the row strobe has been low a cycle
  assert_cas_after_ras_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (!ras_n && $past(!ras_n)));

  // R8: nothing is acknowledged in the cycle after a refresh grant
  assert_no_ack_in_refresh_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_grant |=> !ack);

  // R9: ack lasts one cycle and the row strobe is high when it shows
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  assert_ras_idle_at_ack_R9: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_burst_addr.sv
module dram_burst_addr #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int DATA_W     = 16,
  parameter int BURST      = 4,
  parameter int IDX_W      = (BURST > 1) ? $clog2(BURST) : 1,
  parameter int ADDR_BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic                    load_row,
  input  logic                    load_col,
  input  logic [IDX_W-1:0]        col_idx,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [BURST*DATA_W-1:0] req_wdata,
  output logic [ADDR_BUS_W-1:0]   dram_addr,
  output logic [DATA_W-1:0]       dram_dq_out
);

  logic [ROW_W-1:0]        row_q;
  logic [COL_W-1:0]        col_q;
  logic [BURST*DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0]       words [BURST];
  logic [COL_W-1:0]        col_now;
  logic [ROW_W-1:0]        row_now;

  for (genvar g = 0; g < BURST; g++) begin : g_word
    assign words[g] = wdata_q[g*DATA_W +: DATA_W];
  end

  // column wraps inside the row: the sum is kept to COL_W bits
  assign col_now = col_q + COL_W'(col_idx);
  assign row_now = accept ? req_addr[ROW_W-1:0] : row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      col_q       <= '0;
      wdata_q     <= '0;
      dram_addr   <= '0;
      dram_dq_out <= '0;
    end else begin
      if (accept) begin
        row_q   <= req_addr[ROW_W-1:0];
        col_q   <= req_addr[ROW_W +: COL_W];
        wdata_q <= req_wdata;
      end
      if (load_row) begin
        dram_addr <= ADDR_BUS_W'(row_now);
      end else if (load_col) begin
        dram_addr   <= ADDR_BUS_W'(col_now);
        dram_dq_out <= words[col_idx];
      end
    end
  end

endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_rd,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_rd;
      if (cap_rd) begin
        rd_data <= dq_in;
      end
    end
  end

endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int DATA_W     = 16,
  parameter int BURST      = 4,
  parameter int ADDR_BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic                    req_we,
  input  logic [1:0]              req_mode,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [BURST*DATA_W-1:0] req_wdata,
  input  logic                    refresh_grant,
  output logic                    ack,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic [ADDR_BUS_W-1:0]   dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);

  localparam int IDX_W = (BURST > 1) ? $clog2(BURST) : 1;

  logic             accept, load_row, load_col, cap_rd;
  logic [IDX_W-1:0] col_idx;

  dram_burst_seq #(.BURST(BURST), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_mode(req_mode),
    .refresh_grant(refresh_grant), .accept(accept), .load_row(load_row),
    .load_col(load_col), .col_idx(col_idx), .cap_rd(cap_rd), .ack(ack),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .dq_oe(dram_dq_oe)
  );

  dram_burst_addr #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST(BURST),
    .IDX_W(IDX_W), .ADDR_BUS_W(ADDR_BUS_W)
  ) u_addr (
    .clk(clk), .rst(rst), .accept(accept), .load_row(load_row),
    .load_col(load_col), .col_idx(col_idx), .req_addr(req_addr),
    .req_wdata(req_wdata), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out)
  );

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_rd(cap_rd), .dq_in(dram_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R2: the latched column address holds while the column strobe is low
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> $stable(dram_addr));

  // R7: a write strobe finds the data already driven and unchanged
  assert_write_data_ready_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> (dram_dq_oe && $stable(dram_dq_out)));

  // R7: no read word is reported while a write burst drives the bus
  assert_quiet_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !rd_valid);

endmodule

// File: tb/dram_burst_ctrl_bench.sv
`timescale 1ns/100ps
module dram_burst_ctrl_bench;

  localparam int ROW_W = 8, COL_W = 6, DATA_W = 16, BURST = 4, AW = 8;
  localparam logic [DATA_W-1:0] GARB = 16'hBAD0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_we = 1'b0, refresh_grant = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [BURST*DATA_W-1:0] req_wdata = '0;
  logic ack, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] rd_data, dram_dq_out;
  logic [DATA_W-1:0] dram_dq_in = GARB;
  logic [AW-1:0] dram_addr;

  always #2.5 clk = ~clk;

  dram_burst_ctrl u_dram_burst_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_mode(req_mode),
    .req_addr(req_addr), .req_wdata(req_wdata), .refresh_grant(refresh_grant),
    .ack(ack), .rd_data(rd_data), .rd_valid(rd_valid), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: rows 0..3 kept, indexed {row[1:0], col}
  logic [DATA_W-1:0] mem    [0:255];
  logic [DATA_W-1:0] shadow [0:255];
  logic prev_ras = 1'b1, prev_cas = 1'b1, pend = 1'b0, model_hold = 1'b0;
  logic [DATA_W-1:0] pend_data = '0;
  logic [AW-1:0] row_lat = '0;
  int ras_falls = 0, cas_falls = 0, wr_bad = 0;
  logic [5:0] cas_col [0:7];

  function automatic logic [DATA_W-1:0] init_word(input int i);
    return 16'h5000 | DATA_W'(i);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = init_word(i);
      shadow[i] = init_word(i);
    end
    for (int i = 0; i < 8; i++) cas_col[i] = '0;
  end

  always @(negedge clk) begin
    if (pend) begin
      dram_dq_in = (model_hold || !dram_cas_n) ? pend_data : GARB;
      pend = 1'b0;
    end else if (!model_hold && dram_cas_n) begin
      dram_dq_in = GARB;
    end
    if (prev_ras && !dram_ras_n) begin
      row_lat = dram_addr;
      ras_falls++;
    end
    if (prev_cas && !dram_cas_n) begin
      if (cas_falls < 8) cas_col[cas_falls] = dram_addr[5:0];
      cas_falls++;
      if (!dram_we_n) begin
        if (!dram_dq_oe) wr_bad++;
        mem[{row_lat[1:0], dram_addr[5:0]}] = dram_dq_out;
      end else begin
        pend = 1'b1;
        pend_data = mem[{row_lat[1:0], dram_addr[5:0]}];
      end
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_off(input logic [1:0] m, input int k);
    if (m == 2'd0) return 5 + 5 * k;
    if (m == 2'd1) return 5 + 3 * k;
    return 5 + 2 * k;
  endfunction

  // results of the last burst
  int acks, n_val, t0, ras_at_ack;
  int voff [0:3];
  logic [DATA_W-1:0] vdat [0:3];

  task automatic do_burst(input logic [1:0] m, input logic we, input logic [7:0] row,
                          input logic [5:0] col, input logic [BURST*DATA_W-1:0] wd,
                          input bit chg);
    bit seen = 0;
    model_hold = (m >= 2'd2);
    ras_falls = 0; cas_falls = 0; wr_bad = 0; acks = 0; n_val = 0; ras_at_ack = 0;
    @(negedge clk);
    req = 1'b1; req_we = we; req_mode = m; req_addr = {col, row}; req_wdata = wd;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (ack) begin
        seen = 1; t0 = cyc; acks = 1; ras_at_ack = dram_ras_n;
      end
    end
    check(seen, "R9 ack seen", seen, 1);
    req = 1'b0;
    if (chg) req_mode = 2'd2;
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (ack) acks++;
      if (rd_valid) begin
        if (n_val < 4) begin
          voff[n_val] = cyc - t0;
          vdat[n_val] = rd_data;
        end
        n_val++;
      end
    end
  endtask

  task automatic t_read(input logic [1:0] m, input logic [7:0] row, input logic [5:0] col,
                        input bit chg, input string tag);
    do_burst(m, 1'b0, row, col, '0, chg);
    check(acks == 1, "R9 one ack per request", acks, 1);
    check(ras_at_ack == 1, "R9 row strobe high at ack", ras_at_ack, 1);
    check(n_val == 4, {tag, " valid count"}, n_val, 4);
    check(row_lat == row, "R2 row latched", row_lat, row);
    check(cas_falls == 4, "R3 column strobes", cas_falls, 4);
    check(ras_falls == ((m == 2'd0) ? 4 : 1), {tag, " row strobes"}, ras_falls,
          (m == 2'd0) ? 4 : 1);
    for (int k = 0; k < 4; k++) begin
      logic [5:0] c = col + 6'(k);
      check(cas_col[k] == c, "R3 column order", cas_col[k], c);
      check(voff[k] == exp_off(chg ? 2'd0 : m, k), {tag, " valid cycle"}, voff[k],
            exp_off(chg ? 2'd0 : m, k));
      check(vdat[k] == shadow[{row[1:0], c}], {tag, " read data"}, vdat[k],
            shadow[{row[1:0], c}]);
    end
  endtask

  task automatic t_write(input logic [1:0] m, input logic [7:0] row, input logic [5:0] col,
                         input logic [15:0] base);
    logic [BURST*DATA_W-1:0] wd;
    for (int k = 0; k < 4; k++) wd[k*16 +: 16] = base + 16'(k);
    do_burst(m, 1'b1, row, col, wd, 1'b0);
    check(n_val == 0, "R7 no rd_valid in write", n_val, 0);
    check(wr_bad == 0, "R7 data driven at strobe", wr_bad, 0);
    check(cas_falls == 4, "R3 write column strobes", cas_falls, 4);
    for (int k = 0; k < 4; k++) begin
      logic [5:0] c = col + 6'(k);
      check(cas_col[k] == c, "R3 write column order", cas_col[k], c);
      shadow[{row[1:0], c}] = base + 16'(k);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, ack, rd_valid} == 6'b111000,
          "R1 reset outputs",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, ack, rd_valid}, 6'b111000);
  endtask

  task automatic t_refresh;
    int a = 0, lowras = 0;
    bit seen = 0;
    @(negedge clk);
    refresh_grant = 1'b1; req = 1'b1; req_we = 1'b0; req_mode = 2'd1;
    req_addr = {6'd5, 8'd1};
    model_hold = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ack) a++;
      if (!dram_ras_n) lowras++;
    end
    check(a == 0, "R8 no ack under grant", a, 0);
    check(lowras == 0, "R8 row strobe idle under grant", lowras, 0);
    refresh_grant = 1'b0;
    @(negedge clk);
    seen = ack;
    check(seen, "R8 ack after grant drops", seen, 1);
    req = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_read(2'd0, 8'd1, 6'd4,  1'b0, "R4 conventional");
    t_read(2'd1, 8'd2, 6'd10, 1'b0, "R5 page");
    t_read(2'd2, 8'd3, 6'd20, 1'b0, "R6 extended");
    t_read(2'd3, 8'd1, 6'd30, 1'b0, "R6 extended alt code");
    t_write(2'd1, 8'd2, 6'd62, 16'h1100);
    t_read(2'd0, 8'd2, 6'd62, 1'b0, "R3 wrap readback");
    t_read(2'd1, 8'd2, 6'd0,  1'b0, "R3 wrap low columns");
    t_read(2'd2, 8'd1, 6'd62, 1'b0, "R3 other row untouched");
    t_write(2'd3, 8'd3, 6'd8, 16'h2200);
    t_read(2'd2, 8'd3, 6'd8,  1'b0, "R7 extended write readback");
    t_write(2'd0, 8'd1, 6'd40, 16'h3300);
    t_read(2'd1, 8'd1, 6'd40, 1'b0, "R7 conventional write readback");
    t_refresh();
    t_read(2'd0, 8'd3, 6'd50, 1'b1, "R10 mode held");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule